// File: doc/BRIEF.md
# Flash Block Protection and Power-Down Controller

This block guards a banked NOR flash array model. Each array block holds a two-bit protection status: locked, and frozen (lock-down). Software-side logic issues lock, unlock and freeze requests for a block index. The block applies or refuses each one, and the write-protect pin decides whether a frozen block may still change. Program and erase requests share one request input. One is admitted only if the target block is unlocked, the program-voltage indication is good when the request arrives, and no earlier operation is still running.

The block also holds the power state. Its states are active, standby and deep power-down. Deep power-down is reached only from standby, only while the power-down enable bit of the configuration register is set, and only while the power-down pin is asserted. A second configuration bit picks the pin polarity. While the block is powered down, no protection status, operation or configuration bit can change. A hardware reset locks every block, clears every freeze and clears the configuration register. A read-valid flag then stays low until chip-select or latch-enable shows a falling edge.

Top module: `fpg_guard`

## Requirements
- R1: After reset every block reads locked and not frozen. The power state is standby (1), busy and read-valid are low, and both configuration bits are 0.
- R2: A lock request with code 2'b00 (unlock) clears the block's locked bit, and code 2'b01 (lock) sets it. The change shows on the status outputs in the cycle after the request, and requests to different blocks are independent.
- R3: Code 2'b10 (freeze) sets both the locked and frozen bits. Only reset clears frozen. While wp_pin is 0, any lock request to a frozen block is refused.
- R4: While wp_pin is 1, unlock and lock requests change the locked bit of a frozen block, and its frozen bit stays 1.
- R5: A program/erase request is accepted only under all of these conditions: the power state is not deep, deep entry is not happening at that edge, no operation is busy, vpp_ok is 1, the index is valid and the target block is unlocked. op_accept is high in the cycle after the request.
- R6: op_busy rises with op_accept and stays high until the cycle after op_done. vpp_ok has no effect while busy.
- R7: In deep power-down (state 2), every lock and program/erase request is refused and configuration writes are ignored.
- R8: The power state is encoded 0 = active, 1 = standby, 2 = deep. Outside deep, the state is active when chip_sel_n is 0 or busy is set, and standby otherwise. Deep is entered from standby only, with the enable bit set, the pin asserted and nothing busy. Deep is left for standby when the pin deasserts.
- R9: Configuration bit cfg_pd_high = 0 makes the power-down pin active low. A value of 1 makes it active high.
- R10: Every refused request gives req_err = 1 in the following cycle and changes no state. Lock code 2'b11 is always refused.
- R11: rd_valid rises only after a high-to-low change of chip_sel_n or latch_n seen after reset, and stays high until reset.
- R12: A block index of NUM_BLK or more (12 by default) is refused for both lock and program/erase requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| lk_req | input | 1 | Lock request strobe |
| lk_op | input | 2 | Lock code: 00 unlock, 01 lock, 10 freeze, 11 refused |
| lk_idx | input | IDX_W | Block index of the lock request |
| wp_pin | input | 1 | Write-protect pin; 0 keeps frozen blocks fixed |
| op_req | input | 1 | Program/erase request strobe |
| op_idx | input | IDX_W | Block index of the program/erase request |
| op_done | input | 1 | Running operation has finished |
| vpp_ok | input | 1 | Program voltage above the lockout level |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_pd_en | input | 1 | Power-down enable bit value |
| cfg_pd_high | input | 1 | Power-down pin polarity bit value |
| pd_pin | input | 1 | Deep power-down pin |
| chip_sel_n | input | 1 | Chip select, active low |
| latch_n | input | 1 | Address latch enable, active low |
| op_accept | output | 1 | Request accepted (one cycle) |
| op_busy | output | 1 | Operation in progress |
| req_err | output | 1 | A request was refused (one cycle) |
| blk_locked | output | NUM_BLK | Locked bit per block |
| blk_frozen | output | NUM_BLK | Frozen bit per block |
| pwr_state | output | 2 | Power state code |
| rd_valid | output | 1 | Read data flagged valid |

## Verification
A wrong protection bit shows on blk_locked or blk_frozen in the cycle after the request that corrupted it. A later request to that block then reveals it again through a wrong op_accept or req_err. Power-state errors appear on pwr_state within one edge. A configuration bit that was wrongly written or wrongly ignored is caught at the next deep-entry attempt: the state does or does not go to 2 two cycles later. A stuck busy flag shows as refused requests and a state held at active.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_DEEP    = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    LK_CLEAR  = 2'b00,
    LK_SET    = 2'b01,
    LK_FREEZE = 2'b10,
    LK_RSVD   = 2'b11
  } lkop_e;

  typedef struct packed {
    logic frozen;
    logic locked;
  } blk_stat_t;

  localparam blk_stat_t STAT_RESET = '{frozen: 1'b0, locked: 1'b1};

  // permission check for one lock request against one block's status
  function automatic logic lk_allowed(blk_stat_t s, logic [1:0] op, logic wp_relax);
    return (op != LK_RSVD) && (!s.frozen || wp_relax);
  endfunction

  // status after an allowed lock request
  function automatic blk_stat_t lk_apply(blk_stat_t s, logic [1:0] op);
    blk_stat_t n;
    n = s;
    case (op)
      LK_CLEAR:  n.locked = 1'b0;
      LK_SET:    n.locked = 1'b1;
      LK_FREEZE: begin n.locked = 1'b1; n.frozen = 1'b1; end
      default:   n = s;
    endcase
    return n;
  endfunction

  // power-down pin decode under the polarity bit
  function automatic logic pd_asserted(logic pin, logic act_high);
    return act_high ? pin : ~pin;
  endfunction

endpackage

// File: rtl/fpg_lock_bank.sv
module fpg_lock_bank
  import fpg_pkg::*;
#(
  parameter int NUM_BLK = 12,
  parameter int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [1:0]         lk_op,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic               wp_relax,
  input  logic               in_deep,
  output logic [NUM_BLK-1:0] locked,
  output logic [NUM_BLK-1:0] frozen,
  output logic               lk_rej
);

  localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(NUM_BLK);

  blk_stat_t stat [NUM_BLK];
  blk_stat_t sel_stat;
  logic      idx_ok;
  logic      lk_go;

  assign idx_ok   = {1'b0, lk_idx} < IDX_LIM;
  assign sel_stat = idx_ok ? stat[lk_idx] : STAT_RESET;
  assign lk_go    = lk_req && !in_deep && idx_ok && lk_allowed(sel_stat, lk_op, wp_relax);
  assign lk_rej   = lk_req && !lk_go;

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stat[i] <= STAT_RESET;
      else if (lk_go && (lk_idx == IDX_W'(i)))
        stat[i] <= lk_apply(stat[i], lk_op);
    end

    assign locked[i] = stat[i].locked;
    assign frozen[i] = stat[i].frozen;

    assert_freeze_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat[i].frozen |=> stat[i].frozen);

    assert_wp_holds_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && (lk_idx == IDX_W'(i)) && stat[i].frozen && !wp_relax) |=> $stable(stat[i]));

    assert_deep_freezes_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_deep |=> $stable(stat[i]));
  end

endmodule

// File: rtl/fpg_op_gate.sv
module fpg_op_gate #(
  parameter int NUM_BLK = 12,
  parameter int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_req,
  input  logic [IDX_W-1:0]   op_idx,
  input  logic               op_done,
  input  logic               vpp_ok,
  input  logic [NUM_BLK-1:0] blk_locked,
  input  logic               hold_off,
  output logic               busy,
  output logic               accept,
  output logic               op_rej
);

  localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(NUM_BLK);

  logic idx_ok;
  logic tgt_locked;
  logic op_go;

  assign idx_ok     = {1'b0, op_idx} < IDX_LIM;
  assign tgt_locked = idx_ok ? blk_locked[op_idx] : 1'b1;
  // voltage is looked at here only, on the request edge
  assign op_go      = op_req && !hold_off && !busy && vpp_ok && idx_ok && !tgt_locked;
  assign op_rej     = op_req && !op_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      accept <= 1'b0;
    end else begin
      accept <= op_go;
      if (op_go)        busy <= 1'b1;
      else if (op_done) busy <= 1'b0;
    end
  end

  assert_accept_saw_vpp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(vpp_ok));

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  assert_accept_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> busy);

endmodule

// File: rtl/fpg_power.sv
module fpg_power
  import fpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_pd_en,
  input  logic       cfg_pd_high,
  input  logic       pd_pin,
  input  logic       chip_sel_n,
  input  logic       latch_n,
  input  logic       busy,
  output logic [1:0] pwr_state,
  output logic       in_deep,
  output logic       pd_go,
  output logic       rd_valid
);

  pwr_e pwr_q, pwr_d;
  logic en_q, high_q;
  logic cs_prev, le_prev;
  logic pd_act;
  logic sel_fall;

  assign pd_act   = pd_asserted(pd_pin, high_q);
  assign in_deep  = (pwr_q == PWR_DEEP);
  assign pd_go    = (pwr_q == PWR_STANDBY) && en_q && pd_act && !busy;
  assign sel_fall = (cs_prev && !chip_sel_n) || (le_prev && !latch_n);

  always_comb begin
    if (in_deep)
      pwr_d = pd_act ? PWR_DEEP : PWR_STANDBY;
    else if (pd_go)
      pwr_d = PWR_DEEP;
    else if (!chip_sel_n || busy)
      pwr_d = PWR_ACTIVE;
    else
      pwr_d = PWR_STANDBY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= PWR_STANDBY;
      en_q     <= 1'b0;
      high_q   <= 1'b0;
      cs_prev  <= 1'b0;
      le_prev  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      pwr_q   <= pwr_d;
      cs_prev <= chip_sel_n;
      le_prev <= latch_n;
      if (sel_fall) rd_valid <= 1'b1;
      if (cfg_wr && !in_deep) begin
        en_q   <= cfg_pd_en;
        high_q <= cfg_pd_high;
      end
    end
  end

  assign pwr_state = pwr_q;

  assert_no_deep_from_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == PWR_ACTIVE) |=> (pwr_q != PWR_DEEP));

  assert_no_deep_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_q != PWR_DEEP) && !en_q) |=> (pwr_q != PWR_DEEP));

  assert_cfg_frozen_in_deep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_deep |=> $stable({en_q, high_q}));

  assert_valid_needs_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(sel_fall));

endmodule

// File: rtl/fpg_guard.sv
module fpg_guard #(
  parameter int NUM_BLK = 12,
  parameter int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [1:0]         lk_op,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic               wp_pin,
  input  logic               op_req,
  input  logic [IDX_W-1:0]   op_idx,
  input  logic               op_done,
  input  logic               vpp_ok,
  input  logic               cfg_wr,
  input  logic               cfg_pd_en,
  input  logic               cfg_pd_high,
  input  logic               pd_pin,
  input  logic               chip_sel_n,
  input  logic               latch_n,
  output logic               op_accept,
  output logic               op_busy,
  output logic               req_err,
  output logic [NUM_BLK-1:0] blk_locked,
  output logic [NUM_BLK-1:0] blk_frozen,
  output logic [1:0]         pwr_state,
  output logic               rd_valid
);

  logic in_deep;
  logic pd_go;
  logic lk_rej;
  logic op_rej;

  fpg_power u_power (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_pd_en   (cfg_pd_en),
    .cfg_pd_high (cfg_pd_high),
    .pd_pin      (pd_pin),
    .chip_sel_n  (chip_sel_n),
    .latch_n     (latch_n),
    .busy        (op_busy),
    .pwr_state   (pwr_state),
    .in_deep     (in_deep),
    .pd_go       (pd_go),
    .rd_valid    (rd_valid)
  );

  fpg_lock_bank #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_locks (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_op    (lk_op),
    .lk_idx   (lk_idx),
    .wp_relax (wp_pin),
    .in_deep  (in_deep),
    .locked   (blk_locked),
    .frozen   (blk_frozen),
    .lk_rej   (lk_rej)
  );

  fpg_op_gate #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_ops (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_req     (op_req),
    .op_idx     (op_idx),
    .op_done    (op_done),
    .vpp_ok     (vpp_ok),
    .blk_locked (blk_locked),
    .hold_off   (in_deep || pd_go),
    .busy       (op_busy),
    .accept     (op_accept),
    .op_rej     (op_rej)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= lk_rej || op_rej;
  end

  assert_err_follows_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($past(lk_req) || $past(op_req)));

  assert_accept_follows_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> $past(op_req));

endmodule

// File: tb/fpg_guard_test.sv
module fpg_guard_test;
  localparam int NB = 12;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic lk_req, wp_pin, op_req, op_done, vpp_ok, cfg_wr, cfg_pd_en, cfg_pd_high;
  logic pd_pin, chip_sel_n, latch_n;
  logic [1:0] lk_op;
  logic [IW-1:0] lk_idx, op_idx;
  logic op_accept, op_busy, req_err, rd_valid;
  logic [NB-1:0] blk_locked, blk_frozen;
  logic [1:0] pwr_state;

  fpg_guard #(.NUM_BLK(NB), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_op(lk_op), .lk_idx(lk_idx),
    .wp_pin(wp_pin), .op_req(op_req), .op_idx(op_idx), .op_done(op_done),
    .vpp_ok(vpp_ok), .cfg_wr(cfg_wr), .cfg_pd_en(cfg_pd_en), .cfg_pd_high(cfg_pd_high),
    .pd_pin(pd_pin), .chip_sel_n(chip_sel_n), .latch_n(latch_n),
    .op_accept(op_accept), .op_busy(op_busy), .req_err(req_err),
    .blk_locked(blk_locked), .blk_frozen(blk_frozen), .pwr_state(pwr_state),
    .rd_valid(rd_valid)
  );

  // reference model state
  bit m_lock [NB];
  bit m_frz  [NB];
  bit m_busy, m_acc, m_err, m_en, m_high, m_rv, m_csp, m_lep;
  int m_pwr;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_lock[i] = 1; m_frz[i] = 0; end
    m_busy = 0; m_acc = 0; m_err = 0; m_en = 0; m_high = 0;
    m_rv = 0; m_csp = 0; m_lep = 0; m_pwr = 1;
  endtask

  task automatic idle();
    lk_req = 0; lk_op = 2'b00; lk_idx = '0; op_req = 0; op_idx = '0; op_done = 0;
    cfg_wr = 0; cfg_pd_en = 0; cfg_pd_high = 0;
  endtask

  // next state of the model from its present state and the driven inputs
  task automatic model_step();
    bit lk_ok, lgo, ogo, pact, pgo, deep;
    int li, oi, npwr;
    deep = (m_pwr == 2);
    li = int'(lk_idx); oi = int'(op_idx);
    lk_ok = (li < NB) && (lk_op != 2'b11);
    if (lk_ok && m_frz[li] && !wp_pin) lk_ok = 0;
    lgo = lk_req && !deep && lk_ok;
    pact = (pd_pin == m_high);
    pgo = (m_pwr == 1) && m_en && pact && !m_busy;
    ogo = op_req && !deep && !pgo && !m_busy && vpp_ok && (oi < NB);
    if (ogo && m_lock[oi]) ogo = 0;
    m_err = (lk_req && !lgo) || (op_req && !ogo);
    m_acc = ogo;
    if (deep)                          npwr = pact ? 2 : 1;
    else if (pgo)                      npwr = 2;
    else if (!chip_sel_n || m_busy)    npwr = 0;
    else                               npwr = 1;
    if (ogo) m_busy = 1; else if (op_done) m_busy = 0;
    if (cfg_wr && !deep) begin m_en = cfg_pd_en; m_high = cfg_pd_high; end
    if ((m_csp && !chip_sel_n) || (m_lep && !latch_n)) m_rv = 1;
    m_csp = chip_sel_n; m_lep = latch_n;
    m_pwr = npwr;
    if (lgo) begin
      if (lk_op == 2'b00) m_lock[li] = 0;
      else if (lk_op == 2'b01) m_lock[li] = 1;
      else begin m_lock[li] = 1; m_frz[li] = 1; end
    end
  endtask

  task automatic check_all(string ctx);
    logic [NB-1:0] el, ef;
    for (int i = 0; i < NB; i++) begin el[i] = m_lock[i]; ef[i] = m_frz[i]; end
    chk({ctx, " R2"}, int'(blk_locked), int'(el), "blk_locked");
    chk({ctx, " R3"}, int'(blk_frozen), int'(ef), "blk_frozen");
    chk({ctx, " R5"}, int'(op_accept), int'(m_acc), "op_accept");
    chk({ctx, " R6"}, int'(op_busy), int'(m_busy), "op_busy");
    chk({ctx, " R10"}, int'(req_err), int'(m_err), "req_err");
    chk({ctx, " R8"}, int'(pwr_state), m_pwr, "pwr_state");
    chk({ctx, " R11"}, int'(rd_valid), int'(m_rv), "rd_valid");
  endtask

  task automatic step(string ctx);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
    check_all("R1");
    chk("R1", int'(blk_locked), (1 << NB) - 1, "all locked after reset");
    chk("R1", int'(pwr_state), 1, "standby after reset");
  endtask

  task automatic lock_cmd(int idx, logic [1:0] code, string ctx);
    idle(); lk_req = 1; lk_op = code; lk_idx = IW'(idx);
    step(ctx);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5eed));
    wp_pin = 0; vpp_ok = 1; pd_pin = 1; chip_sel_n = 1; latch_n = 1;
    do_reset();

    // R11: low chip select straight out of reset is not an edge
    chip_sel_n = 0; step("R11");
    chk("R11", int'(rd_valid), 0, "no edge yet");
    chip_sel_n = 1; step("R11");
    chip_sel_n = 0; step("R11");
    chk("R11", int'(rd_valid), 1, "after falling edge");
    chip_sel_n = 1; step("R11");

    // R5: program on a locked block is refused
    idle(); op_req = 1; op_idx = 4'd3; step("R5");
    chk("R10", int'(req_err), 1, "locked target refused");
    lock_cmd(3, 2'b00, "R2");
    chk("R2", int'(blk_locked[3]), 0, "unlock block 3");
    op_req = 1; op_idx = 4'd3; step("R5");
    chk("R5", int'(op_accept), 1, "unlocked target accepted");
    idle(); vpp_ok = 0; step("R6");
    chk("R6", int'(op_busy), 1, "busy kept despite low vpp");
    op_req = 1; op_idx = 4'd3; step("R6");
    chk("R6", int'(req_err), 1, "request while busy refused");
    idle(); op_done = 1; step("R6");
    chk("R6", int'(op_busy), 0, "busy cleared");
    idle(); op_req = 1; op_idx = 4'd3; step("R5");
    chk("R5", int'(req_err), 1, "low vpp refused");
    vpp_ok = 1; idle();

    // R3 / R4: freeze with write-protect low, then relaxed
    wp_pin = 0;
    lock_cmd(5, 2'b10, "R3");
    chk("R3", int'(blk_frozen[5]), 1, "freeze sets frozen");
    lock_cmd(5, 2'b00, "R3");
    chk("R3", int'(blk_locked[5]), 1, "frozen block kept locked");
    chk("R3", int'(req_err), 1, "frozen unlock refused");
    wp_pin = 1;
    lock_cmd(5, 2'b00, "R4");
    chk("R4", int'(blk_locked[5]), 0, "relaxed unlock");
    chk("R4", int'(blk_frozen[5]), 1, "frozen kept");
    lock_cmd(5, 2'b01, "R4");
    chk("R4", int'(blk_locked[5]), 1, "relaxed relock");
    lock_cmd(2, 2'b11, "R10");
    chk("R10", int'(req_err), 1, "reserved code refused");

    // R12: index past the last block
    lock_cmd(14, 2'b00, "R12");
    chk("R12", int'(req_err), 1, "lock index out of range");
    op_req = 1; op_idx = 4'd13; step("R12");
    chk("R12", int'(req_err), 1, "op index out of range");
    idle();

    // R8 / R7 / R9: deep power-down
    pd_pin = 0; step("R8"); step("R8");
    chk("R8", int'(pwr_state), 1, "pin ignored while disabled");
    cfg_wr = 1; cfg_pd_en = 1; cfg_pd_high = 0; step("R8");
    idle(); step("R8");
    chk("R8", int'(pwr_state), 2, "deep entered");
    lock_cmd(0, 2'b00, "R7");
    chk("R7", int'(blk_locked[0]), 1, "lock change blocked in deep");
    chk("R7", int'(req_err), 1, "lock refused in deep");
    cfg_wr = 1; cfg_pd_en = 0; pd_pin = 1; step("R7");
    idle(); chk("R8", int'(pwr_state), 1, "deep left");
    pd_pin = 0; step("R7"); step("R7");
    chk("R7", int'(pwr_state), 2, "cfg write in deep ignored");
    pd_pin = 1; step("R9");
    cfg_wr = 1; cfg_pd_en = 1; cfg_pd_high = 1; step("R9");
    idle(); step("R9");
    chk("R9", int'(pwr_state), 2, "active-high pin enters deep");
    pd_pin = 0; step("R9");
    chk("R9", int'(pwr_state), 1, "active-high pin released");

    // random phase with a reset in the middle
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) begin do_reset(); pd_pin = 1; end
      lk_req = ($urandom % 4) == 0;
      lk_op = 2'($urandom % 4);
      lk_idx = IW'($urandom % 16);
      wp_pin = ($urandom % 2) == 0;
      op_req = ($urandom % 5) == 0;
      op_idx = IW'($urandom % 16);
      op_done = m_busy && (($urandom % 4) == 0);
      vpp_ok = ($urandom % 8) != 0;
      cfg_wr = ($urandom % 40) == 0;
      cfg_pd_en = ($urandom % 3) != 0;
      cfg_pd_high = ($urandom % 2) == 0;
      if (($urandom % 10) == 0) pd_pin = ~pd_pin;
      chip_sel_n = ($urandom % 6) != 0;
      latch_n = ($urandom % 5) != 0;
      step("rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule